// File: doc/BRIEF.md
# I2C Calibration Register Slave

This block is the serial front end of a calibration setting. It holds one 8-bit output code and lets a bus master change, read or freeze it over I2C. The bus lines arrive raw and are resampled into the system clock domain. The block finds START and STOP conditions and matches a fixed 6-bit device address. It then decodes a two-byte write or a one-byte read. The slave side of SDA is an open-drain pull-down enable.

A write carries the code split over both bytes. Bit 1 of the address byte holds the code's least significant bit. The second byte holds the upper seven bits, together with a mode bit that picks one of two actions: update the register, or ask an external sequencer to copy the present register value into non-volatile storage. A write-protect input gates both actions, but the slave still acknowledges traffic while protected. After power-up the register can be loaded from a stored value through a load strobe, so the output is correct without any bus traffic.

Top module: `calib_i2c_regif`

## Requirements
- R1: After reset the register reads 0x00, the SDA pull-down is released and no program request is raised.
- R2: A one-cycle `load_valid` copies `load_value` into the register on the next clock. It takes priority over a bus write in the same cycle.
- R3: A first byte whose bits 7..2 equal DEV_ADDR (default 100111) is acknowledged: SDA is held low during the ninth clock. Any other address gets no acknowledge, and later bytes are also not acknowledged until the next START or STOP.
- R4: A write (bit 0 of the first byte = 0) with write-protect high and bit 0 of the second byte = 1 sets the register to {second byte bits 7..1, first byte bit 1}.
- R5: A write with write-protect high and bit 0 of the second byte = 0 raises `prog_req` and leaves the register unchanged.
- R6: With write-protect low, both bytes of a write are still acknowledged and reads still work, but the register keeps its value and `prog_req` stays low.
- R7: A read (bit 0 of the first byte = 1) returns the register MSB first in the next byte. After a master acknowledge the same value is sent again. A master NACK ends the read.
- R8: The register and `prog_req` change only after the falling SCL edge that ends the ninth clock of the second byte. A code whose eight bits have all arrived does not reach the output before that edge.
- R9: A repeated START at any bit position drops the byte in progress and restarts address reception, with no effect on the register.
- R10: `prog_req` is high for exactly one clock cycle per accepted program command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line as seen on the wire |
| wp_in | input | 1 | Write protect; high allows changes |
| load_valid | input | 1 | One-cycle strobe to load the stored value |
| load_value | input | 8 | Stored code from non-volatile memory |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| reg_value | output | 8 | Present output code |
| prog_req | output | 1 | One-cycle request to program storage |

## Verification
The bench builds the block with the default address 100111 and three synchronizer stages instead of two. The longer input path pushes the slave's reaction to each SCL edge closer to the master's own SDA changes, so the margin of the acknowledge and the read-data timing is tested under a slower path. With the address left at its default, the bench can split the code across the two bytes exactly as the decode requires. It can also send a near-miss address, 101000, that shares the leading bit.

// File: rtl/calib_pkg.sv
// Shared constants and types for the calibration register slave.
// Assumes byte-wide transfers with the address in the upper bits.
package calib_pkg;
    localparam int BYTE_BITS = 8;
    localparam int ADDR_BITS = 6;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } bus_state_t;
endpackage

// File: rtl/calib_sync.sv
// Multi-stage resynchronizer, one chain per bit.
// Assumes STAGES >= 2; each bit has its own reset value.
module calib_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // shift the raw input through the chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], d[g]};
        end

        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/calib_busevt.sv
// Bus event detector: SCL edges, START and STOP from the resynchronized lines.
// Assumes both lines idle high; outputs are single-cycle pulses.
module calib_busevt (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    logic scl_q, sda_q;

    // one-cycle history of both lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // edge and condition decode
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
        sda_bit   = sda_s;
    end
endmodule

// File: rtl/calib_fsm.sv
// Protocol engine: address match, write decode, read shift-out, ACK drive.
// Assumes event pulses from calib_busevt; emits commit pulses after the
// ninth clock of the second write byte and leaves gating to the register.
module calib_fsm
    import calib_pkg::*;
#(
    parameter logic [ADDR_BITS-1:0] DEV_ADDR = 6'b100111
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 start_det,
    input  logic                 stop_det,
    input  logic                 sda_bit,
    input  logic [BYTE_BITS-1:0] reg_value,
    output logic                 sda_drive_low,
    output logic                 commit_wr,
    output logic                 commit_prog,
    output logic [BYTE_BITS-1:0] wr_data,
    output bus_state_t           fsm_state
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

    bus_state_t           st;
    logic [CNT_W-1:0]     cnt;
    logic [BYTE_BITS-1:0] sh;
    logic [BYTE_BITS-1:0] tx;
    logic                 d0_q;
    logic                 rw_q;
    logic                 nack_q;
    logic                 drv;

    // main protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            cnt         <= '0;
            sh          <= '0;
            tx          <= '0;
            d0_q        <= 1'b0;
            rw_q        <= 1'b0;
            nack_q      <= 1'b0;
            drv         <= 1'b0;
            commit_wr   <= 1'b0;
            commit_prog <= 1'b0;
            wr_data     <= '0;
        end else begin
            commit_wr   <= 1'b0;
            commit_prog <= 1'b0;
            if (start_det) begin
                st  <= ST_ADDR;
                cnt <= '0;
                drv <= 1'b0;
            end else if (stop_det) begin
                st  <= ST_IDLE;
                drv <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_BITS-2:0], sda_bit};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            if (sh[BYTE_BITS-1:BYTE_BITS-ADDR_BITS] == DEV_ADDR) begin
                                st   <= ST_AACK;
                                drv  <= 1'b1;
                                d0_q <= sh[1];
                                rw_q <= sh[0];
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw_q) begin
                                st  <= ST_RDATA;
                                tx  <= reg_value;
                                drv <= ~reg_value[BYTE_BITS-1];
                            end else begin
                                st  <= ST_WDATA;
                                drv <= 1'b0;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_BITS-2:0], sda_bit};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST_BIT) begin
                            st  <= ST_WACK;
                            drv <= 1'b1;
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            st          <= ST_SKIP;
                            drv         <= 1'b0;
                            commit_wr   <= sh[0];
                            commit_prog <= ~sh[0];
                            wr_data     <= {sh[BYTE_BITS-1:1], d0_q};
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                st  <= ST_RACK;
                                drv <= 1'b0;
                            end else begin
                                tx  <= {tx[BYTE_BITS-2:0], 1'b0};
                                drv <= ~tx[BYTE_BITS-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            nack_q <= sda_bit;
                        end else if (scl_fall) begin
                            if (nack_q) begin
                                st <= ST_SKIP;
                            end else begin
                                st  <= ST_RDATA;
                                cnt <= '0;
                                tx  <= reg_value;
                                drv <= ~reg_value[BYTE_BITS-1];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_drive_low = drv;
    assign fsm_state     = st;
endmodule

// File: rtl/calib_regfile.sv
// Output code register with power-up load and write-protect gating.
// Assumes commit pulses are one cycle; load wins over a bus commit.
module calib_regfile
    import calib_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wp_ok,
    input  logic                 load_valid,
    input  logic [BYTE_BITS-1:0] load_value,
    input  logic                 commit_wr,
    input  logic                 commit_prog,
    input  logic [BYTE_BITS-1:0] wr_data,
    output logic [BYTE_BITS-1:0] reg_value,
    output logic                 prog_req
);
    // hold the code and issue gated program strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_value <= '0;
            prog_req  <= 1'b0;
        end else begin
            prog_req <= commit_prog & wp_ok;
            if (load_valid)             reg_value <= load_value;
            else if (commit_wr && wp_ok) reg_value <= wr_data;
        end
    end
endmodule

// File: rtl/calib_i2c_regif.sv
// Top: I2C slave holding one 8-bit calibration code.
// Assumes raw bus lines and write protect are asynchronous to clk.
module calib_i2c_regif
    import calib_pkg::*;
#(
    parameter logic [ADDR_BITS-1:0] DEV_ADDR    = 6'b100111,
    parameter int                   SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic                 wp_in,
    input  logic                 load_valid,
    input  logic [BYTE_BITS-1:0] load_value,
    output logic                 sda_drive_low,
    output logic [BYTE_BITS-1:0] reg_value,
    output logic                 prog_req
);
    logic [2:0]           sync_q;
    logic                 scl_s, sda_s, wp_ok;
    logic                 scl_rise, scl_fall, start_det, stop_det, sda_bit;
    logic                 commit_wr, commit_prog;
    logic [BYTE_BITS-1:0] wr_data;
    bus_state_t           fsm_state;

    calib_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b011)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({wp_in, sda_in, scl_in}),
        .q    (sync_q)
    );

    assign scl_s = sync_q[0];
    assign sda_s = sync_q[1];
    assign wp_ok = sync_q[2];

    calib_busevt u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_bit  (sda_bit)
    );

    calib_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .sda_bit      (sda_bit),
        .reg_value    (reg_value),
        .sda_drive_low(sda_drive_low),
        .commit_wr    (commit_wr),
        .commit_prog  (commit_prog),
        .wr_data      (wr_data),
        .fsm_state    (fsm_state)
    );

    calib_regfile u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wp_ok      (wp_ok),
        .load_valid (load_valid),
        .load_value (load_value),
        .commit_wr  (commit_wr),
        .commit_prog(commit_prog),
        .wr_data    (wr_data),
        .reg_value  (reg_value),
        .prog_req   (prog_req)
    );
endmodule

// File: rtl/calib_i2c_regif_chk.sv
// Property checker for calib_i2c_regif, attached by bind below.
module calib_i2c_regif_chk
    import calib_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wp_ok,
    input logic                 load_valid,
    input logic [BYTE_BITS-1:0] reg_value,
    input logic                 prog_req,
    input logic                 sda_drive_low,
    input logic                 commit_wr,
    input logic                 start_det,
    input bus_state_t           fsm_state
);
    // R10: program strobe lasts a single cycle
    a_r10_prog_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    // R6: no program strobe unless protection was lifted
    a_r6_prog_needs_wp: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> $past(wp_ok));

    // R5: a program strobe leaves the code alone
    a_r5_prog_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> ($stable(reg_value) || $past(load_valid)));

    // R8: the code moves only on a gated commit or a load
    a_r8_code_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_value) |-> ($past(commit_wr && wp_ok) || $past(load_valid)));

    // R3: SDA is pulled only in acknowledge or read-data phases
    a_r3_drive_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_low |-> (fsm_state == ST_AACK || fsm_state == ST_WACK ||
                           fsm_state == ST_RDATA));

    // R9: any START restarts address reception
    a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (fsm_state == ST_ADDR));
endmodule

bind calib_i2c_regif calib_i2c_regif_chk u_chk (.*);

// File: tb/sim_calib_i2c_regif.sv
// Scoreboard bench: driver tasks queue expected items, a monitor compares.
module sim_calib_i2c_regif;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp_in = 1'b1;
    logic       load_valid = 1'b0;
    logic [7:0] load_value = '0;
    logic       sda_drive_low;
    logic [7:0] reg_value;
    logic       prog_req;
    logic       sda_line;

    assign sda_line = sda_m & ~sda_drive_low;

    always #2.5 clk = ~clk;

    calib_i2c_regif #(.DEV_ADDR(6'b100111), .SYNC_STAGES(3)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_m),
        .sda_in       (sda_line),
        .wp_in        (wp_in),
        .load_valid   (load_valid),
        .load_value   (load_value),
        .sda_drive_low(sda_drive_low),
        .reg_value    (reg_value),
        .prog_req     (prog_req)
    );

    int    exp_v[$];
    string exp_t[$];
    int    act_v[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    prog_cycles = 0;
    int    model_reg = 0;
    int    model_prog = 0;
    bit    done = 0;

    // monitor: count program strobe cycles
    always @(negedge clk) if (rst_n && prog_req) prog_cycles++;

    // monitor: pop and compare
    always @(negedge clk) begin
        while (exp_v.size() > 0 && act_v.size() > 0) begin
            int e, a;
            string t;
            e = exp_v.pop_front();
            t = exp_t.pop_front();
            a = act_v.pop_front();
            n_cmp++;
            if (a != e) begin
                n_bad++;
                $display("FAIL %s: actual %0h expected %0h", t, a, e);
            end
        end
    end

    task automatic expect_item(input string t, input int v);
        exp_t.push_back(t);
        exp_v.push_back(v);
    endtask

    task automatic observe(input int v);
        act_v.push_back(v);
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q(); wait_q();
    endtask

    task automatic clock_bit(input logic b, output logic smp);
        sda_m = b;    wait_q();
        scl_m = 1'b1; wait_q();
        smp = sda_line; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
        clock_bit(1'b1, ack);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            v[i] = s;
        end
        clock_bit(mack, s);
    endtask

    // full write: R3 ack, R8 hold before ninth clock, R4/R5/R6 outcome
    task automatic do_write(input logic [7:0] val, input logic prog, input string tag);
        logic a, s;
        logic [7:0] b2;
        b2 = {val[7:1], ~prog};
        bus_start();
        send_byte({6'b100111, val[0], 1'b0}, a);
        expect_item("R3 address ack", 0); observe(a);
        for (int i = 7; i >= 0; i--) clock_bit(b2[i], s);
        expect_item("R8 code held before ninth clock", model_reg); observe(reg_value);
        expect_item("R8 no program strobe before ninth clock", model_prog); observe(prog_cycles);
        clock_bit(1'b1, a);
        expect_item(wp_in ? "R4 data ack" : "R6 data ack while protected", 0); observe(a);
        bus_stop();
        if (wp_in) begin
            if (prog) model_prog++;
            else      model_reg = val;
        end
        expect_item(tag, model_reg); observe(reg_value);
        expect_item("R5 R10 program strobe cycles", model_prog); observe(prog_cycles);
    endtask

    task automatic do_read(input int nbytes, input string tag);
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte({6'b100111, 1'b0, 1'b1}, a);
        expect_item("R3 read address ack", 0); observe(a);
        for (int k = 0; k < nbytes; k++) begin
            recv_byte((k == nbytes - 1), v);
            expect_item(tag, model_reg); observe(v);
        end
        bus_stop();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic a, s;
        logic [7:0] v;
        repeat (6) @(negedge clk);
        // R1 reset state
        expect_item("R1 reset code", 0);       observe(reg_value);
        expect_item("R1 reset sda released", 0); observe(sda_drive_low);
        expect_item("R1 no program strobe", 0); observe(prog_req);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        expect_item("R1 code after reset release", 0); observe(reg_value);

        // R2 power-up load
        load_value = 8'hA5; load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        model_reg = 'hA5;
        expect_item("R2 load copies stored value", model_reg); observe(reg_value);

        // R4 writes with even and odd low bit
        do_write(8'h3C, 1'b0, "R4 write code 3C");
        do_write(8'h81, 1'b0, "R4 write code 81 low bit from address byte");

        // R7 reads: one byte, then two with master ack
        do_read(1, "R7 read returns code");
        do_read(2, "R7 repeated byte after master ack");

        // R5 program command
        do_write(8'h00, 1'b1, "R5 program keeps code");

        // R6 protection low
        wp_in = 1'b0; repeat (10) @(negedge clk);
        do_write(8'h55, 1'b0, "R6 protected write ignored");
        do_write(8'h55, 1'b1, "R6 protected program ignored");
        do_read(1, "R6 read while protected");
        wp_in = 1'b1; repeat (10) @(negedge clk);

        // R3 foreign address: no ack, next byte not acked either
        bus_start();
        send_byte(8'hA0, a);
        expect_item("R3 foreign address no ack", 1); observe(a);
        send_byte(8'h11, a);
        expect_item("R3 skipped byte no ack", 1); observe(a);
        bus_stop();
        expect_item("R3 foreign write ignored", model_reg); observe(reg_value);

        // R9 repeated start in the middle of a data byte
        bus_start();
        send_byte(8'h9C, a);
        expect_item("R9 address ack before abort", 0); observe(a);
        for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
        expect_item("R9 aborted byte has no effect", model_reg); observe(reg_value);
        send_byte(8'h9C, a);
        expect_item("R9 address ack after restart", 0); observe(a);
        send_byte(8'h5B, a);
        expect_item("R9 data ack after restart", 0); observe(a);
        bus_stop();
        model_reg = 'h5A;
        expect_item("R9 write after restart lands", model_reg); observe(reg_value);

        // R2 load overrides bus value later
        load_value = 8'h0F; load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        model_reg = 'h0F;
        expect_item("R2 load after bus write", model_reg); observe(reg_value);
        do_read(1, "R7 read after load");

        repeat (5) @(negedge clk);
        if (exp_v.size() != 0 || act_v.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0 left", exp_v.size() + act_v.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule